// File: doc/BRIEF.md
# Assignable Transmit/Receive FIFO Pair

This block holds two byte-wide FIFOs of eight entries each, one carrying transmit data and one carrying receive data. They are shared by a bus master engine and a bus slave engine. A separate configuration input for each FIFO selects which engine owns it. Both FIFOs can go to the master, both can go to the slave, or they can be split between the two in either direction. The owning engine has full push, pop and status access. The other engine always sees that FIFO as empty: level zero, empty flag high, full flag low and read data zero. Its pushes and pops are discarded.

Each engine gets its own push and pop port, its own level, full and empty flags, and show-ahead read data for each FIFO. The owner latches its configuration input only while that FIFO is empty, so a request to move a FIFO that still holds bytes has no effect until the FIFO drains. Six raw interrupt bits each have a mask bit and a write-one-to-clear strobe:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | TX threshold | TX level falls to or below the TX trigger |
| 1 | RX threshold | RX level rises above the RX trigger |
| 2 | RX full | RX FIFO becomes full |
| 3 | TX empty | TX FIFO drains to empty after holding data |
| 4 | Overflow | Sticky; a push to a full FIFO was dropped |
| 5 | Underflow | Sticky; a pop from an empty FIFO was dropped |

A small state machine drives the TX-empty bit. It has four states:

- IDLE: the reset state; the FIFO is empty and the bit is not armed.
- FILLED: the FIFO holds data.
- DRAINED: the FIFO is empty and the raw bit is set.
- ACKED: the FIFO is empty and the bit has been cleared.

Its transitions are:

- IDLE→FILLED and ACKED→FILLED when the level becomes nonzero.
- FILLED→DRAINED when the level reaches zero.
- DRAINED→FILLED on refill.
- DRAINED→ACKED on a clear strobe.

Top module: `xfer_fifo_pair`

## Requirements
- R1: Each FIFO stores exactly 8 bytes. After 8 accepted pushes the owner sees level 8 and the full flag high.
- R2: The TX owner is the slave when `tx_owner_slave` is 1 and the master when it is 0. The RX owner is chosen the same way by `rx_owner_slave`. The two choices are independent of each other.
- R3: The non-owning engine sees level 0, empty 1, full 0 and read data 0 for that FIFO. Its push and pop strobes change nothing.
- R4: A change on `cfg_tx_slave` or `cfg_rx_slave` takes effect one cycle after it is seen, and only while that FIFO is empty. While the FIFO holds data the owner is unchanged.
- R5: Raw bit 1 (RX threshold) sets when the RX level goes from at or below `rx_trig` to above it.
- R6: Raw bit 0 (TX threshold) sets when the TX level goes from above `tx_trig` to at or below it.
- R7: Raw bit 2 (RX full) sets when the RX FIFO becomes full.
- R8: Raw bit 3 (TX empty) sets when the TX FIFO drains to empty after holding data. If it is cleared while the FIFO is still empty it stays at 0 until the FIFO has been refilled and drained again. It is 0 after reset.
- R9: A push to a full FIFO is dropped and sets sticky raw bit 4. A pop from an empty FIFO is dropped and sets sticky raw bit 5. Both bits hold until cleared.
- R10: `irq_masked` equals `irq_raw & irq_mask`, and `irq` is the OR of `irq_masked`. A 1 in bit n of `irq_clr` clears raw bit n.
- R11: Bytes leave each FIFO in the order they were accepted. Read data shows the oldest byte before it is popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_slave | input | 1 | Requested TX owner (1 = slave) |
| cfg_rx_slave | input | 1 | Requested RX owner (1 = slave) |
| tx_trig | input | 4 | TX trigger level |
| rx_trig | input | 4 | RX trigger level |
| m_tx_push | input | 1 | Master TX push |
| m_tx_wdata | input | 8 | Master TX push data |
| m_tx_pop | input | 1 | Master TX pop |
| m_tx_rdata | output | 8 | Master TX head byte |
| m_tx_level | output | 4 | Master view of TX level |
| m_tx_empty | output | 1 | Master view of TX empty |
| m_tx_full | output | 1 | Master view of TX full |
| m_rx_push | input | 1 | Master RX push |
| m_rx_wdata | input | 8 | Master RX push data |
| m_rx_pop | input | 1 | Master RX pop |
| m_rx_rdata | output | 8 | Master RX head byte |
| m_rx_level | output | 4 | Master view of RX level |
| m_rx_empty | output | 1 | Master view of RX empty |
| m_rx_full | output | 1 | Master view of RX full |
| s_tx_push | input | 1 | Slave TX push |
| s_tx_wdata | input | 8 | Slave TX push data |
| s_tx_pop | input | 1 | Slave TX pop |
| s_tx_rdata | output | 8 | Slave TX head byte |
| s_tx_level | output | 4 | Slave view of TX level |
| s_tx_empty | output | 1 | Slave view of TX empty |
| s_tx_full | output | 1 | Slave view of TX full |
| s_rx_push | input | 1 | Slave RX push |
| s_rx_wdata | input | 8 | Slave RX push data |
| s_rx_pop | input | 1 | Slave RX pop |
| s_rx_rdata | output | 8 | Slave RX head byte |
| s_rx_level | output | 4 | Slave view of RX level |
| s_rx_empty | output | 1 | Slave view of RX empty |
| s_rx_full | output | 1 | Slave view of RX full |
| tx_owner_slave | output | 1 | Effective TX owner (1 = slave) |
| rx_owner_slave | output | 1 | Effective RX owner (1 = slave) |
| irq_mask | input | 6 | Interrupt mask |
| irq_clr | input | 6 | Write-one-to-clear strobes |
| irq_raw | output | 6 | Raw interrupt status |
| irq_masked | output | 6 | Masked interrupt status |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the TX-empty bit sitting in the ACKED state. This requires a fill, a full drain, a clear while the FIFO is still empty, and then several idle cycles during which the bit must stay low. The bench sets this up by pushing four bytes, popping them one at a time, pulsing the clear and waiting. It then refills and drains a single byte to show that the bit re-arms. A refused reassignment is also awkward to reach. The bench produces it by moving the TX FIFO to the slave and loading one byte, then requesting the master and confirming that the owner and the level are unchanged until the slave drains the byte.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
    localparam int NIRQ      = 6;
    localparam int IRQ_TXTH  = 0;
    localparam int IRQ_RXTH  = 1;
    localparam int IRQ_RXFUL = 2;
    localparam int IRQ_TXEMP = 3;
    localparam int IRQ_OVF   = 4;
    localparam int IRQ_UDF   = 5;

    typedef enum logic [1:0] {
        TXE_IDLE,
        TXE_FILLED,
        TXE_DRAINED,
        TXE_ACKED
    } txe_state_t;
endpackage

// File: rtl/xfp_store.sv
module xfp_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovf_evt,
    output logic          udf_evt
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf_evt = push && full;
    assign udf_evt = pop && empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/xfp_txe_fsm.sv
module xfp_txe_fsm
    import xfp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic clr,
    output logic raw
);
    txe_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXE_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TXE_IDLE:    if (!empty) nxt = TXE_FILLED;
            TXE_FILLED:  if (empty)  nxt = TXE_DRAINED;
            TXE_DRAINED: if (!empty) nxt = TXE_FILLED;
                         else if (clr) nxt = TXE_ACKED;
            TXE_ACKED:   if (!empty) nxt = TXE_FILLED;
            default:     nxt = TXE_IDLE;
        endcase
    end

    always_comb begin
        raw = (state == TXE_DRAINED);
    end
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
    import xfp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_tx_slave,
    input  logic            cfg_rx_slave,
    input  logic [LW-1:0]   tx_trig,
    input  logic [LW-1:0]   rx_trig,
    input  logic            m_tx_push,
    input  logic [DW-1:0]   m_tx_wdata,
    input  logic            m_tx_pop,
    output logic [DW-1:0]   m_tx_rdata,
    output logic [LW-1:0]   m_tx_level,
    output logic            m_tx_empty,
    output logic            m_tx_full,
    input  logic            m_rx_push,
    input  logic [DW-1:0]   m_rx_wdata,
    input  logic            m_rx_pop,
    output logic [DW-1:0]   m_rx_rdata,
    output logic [LW-1:0]   m_rx_level,
    output logic            m_rx_empty,
    output logic            m_rx_full,
    input  logic            s_tx_push,
    input  logic [DW-1:0]   s_tx_wdata,
    input  logic            s_tx_pop,
    output logic [DW-1:0]   s_tx_rdata,
    output logic [LW-1:0]   s_tx_level,
    output logic            s_tx_empty,
    output logic            s_tx_full,
    input  logic            s_rx_push,
    input  logic [DW-1:0]   s_rx_wdata,
    input  logic            s_rx_pop,
    output logic [DW-1:0]   s_rx_rdata,
    output logic [LW-1:0]   s_rx_level,
    output logic            s_rx_empty,
    output logic            s_rx_full,
    output logic            tx_owner_slave,
    output logic            rx_owner_slave,
    input  logic [NIRQ-1:0] irq_mask,
    input  logic [NIRQ-1:0] irq_clr,
    output logic [NIRQ-1:0] irq_raw,
    output logic [NIRQ-1:0] irq_masked,
    output logic            irq
);
    localparam int NF = 2; // index 0 = TX, index 1 = RX

    logic [NF-1:0] own_s, cfg_s;
    logic [NF-1:0] m_push, s_push, m_pop, s_pop;
    logic [NF-1:0] push_f, pop_f, full_f, empty_f, ovf_f, udf_f;
    logic [DW-1:0] m_wd [NF];
    logic [DW-1:0] s_wd [NF];
    logic [DW-1:0] wd_f [NF];
    logic [DW-1:0] rd_f [NF];
    logic [LW-1:0] lvl_f [NF];

    assign cfg_s  = {cfg_rx_slave, cfg_tx_slave};
    assign m_push = {m_rx_push, m_tx_push};
    assign s_push = {s_rx_push, s_tx_push};
    assign m_pop  = {m_rx_pop, m_tx_pop};
    assign s_pop  = {s_rx_pop, s_tx_pop};
    assign m_wd[0] = m_tx_wdata;
    assign m_wd[1] = m_rx_wdata;
    assign s_wd[0] = s_tx_wdata;
    assign s_wd[1] = s_rx_wdata;

    for (genvar f = 0; f < NF; f++) begin : g_fifo
        assign push_f[f] = own_s[f] ? s_push[f] : m_push[f];
        assign pop_f[f]  = own_s[f] ? s_pop[f]  : m_pop[f];
        assign wd_f[f]   = own_s[f] ? s_wd[f]   : m_wd[f];

        xfp_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
            .clk(clk), .rst_n(rst_n),
            .push(push_f[f]), .wdata(wd_f[f]), .pop(pop_f[f]),
            .rdata(rd_f[f]), .level(lvl_f[f]),
            .full(full_f[f]), .empty(empty_f[f]),
            .ovf_evt(ovf_f[f]), .udf_evt(udf_f[f])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          own_s[f] <= 1'b0;
            else if (empty_f[f]) own_s[f] <= cfg_s[f];
        end
    end

    assign tx_owner_slave = own_s[0];
    assign rx_owner_slave = own_s[1];

    // Engine views: the non-owner always sees an empty FIFO
    assign m_tx_rdata = own_s[0] ? '0 : rd_f[0];
    assign m_tx_level = own_s[0] ? '0 : lvl_f[0];
    assign m_tx_empty = own_s[0] | empty_f[0];
    assign m_tx_full  = !own_s[0] & full_f[0];
    assign s_tx_rdata = own_s[0] ? rd_f[0] : '0;
    assign s_tx_level = own_s[0] ? lvl_f[0] : '0;
    assign s_tx_empty = !own_s[0] | empty_f[0];
    assign s_tx_full  = own_s[0] & full_f[0];
    assign m_rx_rdata = own_s[1] ? '0 : rd_f[1];
    assign m_rx_level = own_s[1] ? '0 : lvl_f[1];
    assign m_rx_empty = own_s[1] | empty_f[1];
    assign m_rx_full  = !own_s[1] & full_f[1];
    assign s_rx_rdata = own_s[1] ? rd_f[1] : '0;
    assign s_rx_level = own_s[1] ? lvl_f[1] : '0;
    assign s_rx_empty = !own_s[1] | empty_f[1];
    assign s_rx_full  = own_s[1] & full_f[1];

    // Edge-triggered threshold / full conditions
    logic [2:0] cond, cond_q;
    logic [NIRQ-1:0] lat;
    logic txe_raw;

    assign cond = {full_f[1], (lvl_f[1] > rx_trig), (lvl_f[0] <= tx_trig)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 3'b001;
            lat    <= '0;
        end else begin
            cond_q <= cond;
            lat[2:0] <= (lat[2:0] & ~irq_clr[2:0]) | (cond & ~cond_q);
            lat[IRQ_TXEMP] <= 1'b0;
            lat[IRQ_OVF] <= (lat[IRQ_OVF] & ~irq_clr[IRQ_OVF]) | (|ovf_f);
            lat[IRQ_UDF] <= (lat[IRQ_UDF] & ~irq_clr[IRQ_UDF]) | (|udf_f);
        end
    end

    xfp_txe_fsm txe_i (
        .clk(clk), .rst_n(rst_n), .empty(empty_f[0]),
        .clr(irq_clr[IRQ_TXEMP]), .raw(txe_raw)
    );

    always_comb begin
        irq_raw            = lat;
        irq_raw[IRQ_TXEMP] = txe_raw;
    end

    assign irq_masked = irq_raw & irq_mask;
    assign irq        = |irq_masked;
endmodule

// File: rtl/xfp_checker.sv
module xfp_checker #(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] m_tx_level,
    input logic [LW-1:0] s_tx_level,
    input logic          m_tx_full,
    input logic          m_tx_empty,
    input logic          tx_owner_slave,
    input logic [5:0]    irq_raw,
    input logic [5:0]    irq_clr,
    input logic          s_tx_push
);
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m_tx_level <= LW'(DEPTH) && s_tx_level <= LW'(DEPTH));

    p_full_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m_tx_full |-> (m_tx_level == LW'(DEPTH)));

    p_nonowner_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_owner_slave |-> (m_tx_empty && m_tx_level == '0 && !m_tx_full));

    p_reassign_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_owner_slave != $past(tx_owner_slave)) |->
            ($past(m_tx_level) == '0 && $past(s_tx_level) == '0));

    p_txe_stays_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr[3] && m_tx_level == '0 && s_tx_level == '0 && !s_tx_push) |=> !irq_raw[3]);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw[4] && !irq_clr[4]) |=> irq_raw[4]);
endmodule

bind xfer_fifo_pair xfp_checker #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .m_tx_level(m_tx_level), .s_tx_level(s_tx_level),
    .m_tx_full(m_tx_full), .m_tx_empty(m_tx_empty),
    .tx_owner_slave(tx_owner_slave),
    .irq_raw(irq_raw), .irq_clr(irq_clr), .s_tx_push(s_tx_push)
);

// File: tb/xfer_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module xfer_fifo_pair_tb_top;
    logic clk = 0, rst_n = 0;
    logic cfg_tx_slave = 0, cfg_rx_slave = 0;
    logic [3:0] tx_trig = 0, rx_trig = 0;
    logic m_tx_push = 0, m_tx_pop = 0, m_rx_push = 0, m_rx_pop = 0;
    logic s_tx_push = 0, s_tx_pop = 0, s_rx_push = 0, s_rx_pop = 0;
    logic [7:0] m_tx_wdata = 0, m_rx_wdata = 0, s_tx_wdata = 0, s_rx_wdata = 0;
    logic [7:0] m_tx_rdata, m_rx_rdata, s_tx_rdata, s_rx_rdata;
    logic [3:0] m_tx_level, m_rx_level, s_tx_level, s_rx_level;
    logic m_tx_empty, m_tx_full, m_rx_empty, m_rx_full;
    logic s_tx_empty, s_tx_full, s_rx_empty, s_rx_full;
    logic tx_owner_slave, rx_owner_slave, irq;
    logic [5:0] irq_mask = 0, irq_clr = 0, irq_raw, irq_masked;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    xfer_fifo_pair dut_i (.*);

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_all();
        irq_clr = '1; tick(); irq_clr = '0; tick();
    endtask

    task automatic mtx_push(logic [7:0] d);
        m_tx_push = 1; m_tx_wdata = d; tick(); m_tx_push = 0;
    endtask
    task automatic mtx_pop(output logic [7:0] d);
        d = m_tx_rdata; m_tx_pop = 1; tick(); m_tx_pop = 0;
    endtask
    task automatic mrx_push(logic [7:0] d);
        m_rx_push = 1; m_rx_wdata = d; tick(); m_rx_push = 0;
    endtask
    task automatic mrx_pop(output logic [7:0] d);
        d = m_rx_rdata; m_rx_pop = 1; tick(); m_rx_pop = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset level", m_tx_level, 0);
        chk("R3 reset empty", {m_tx_empty, m_rx_empty, s_tx_empty, s_rx_empty}, 4'hf);
        chk("R8 reset raw", irq_raw, 0);
        chk("R10 reset irq", irq, 0);
    endtask

    task automatic t_order_full();
        logic [7:0] d;
        for (int i = 1; i <= 9; i++) mtx_push(8'(i * 16 + i));
        chk("R1 level at full", m_tx_level, 8);
        chk("R1 full flag", m_tx_full, 1);
        tick();
        chk("R9 overflow sticky", irq_raw[4], 1);
        for (int i = 1; i <= 8; i++) begin
            mtx_pop(d);
            chk("R11 order", d, i * 16 + i);
        end
        chk("R9 drained", m_tx_empty, 1);
        m_tx_pop = 1; tick(); m_tx_pop = 0; tick();
        chk("R9 underflow sticky", irq_raw[5], 1);
        chk("R9 level after underflow", m_tx_level, 0);
        tick(2);
        chk("R9 overflow holds", irq_raw[4], 1);
    endtask

    task automatic t_nonowner();
        logic [7:0] d;
        clr_all();
        cfg_tx_slave = 1; tick(2);
        chk("R2 tx owner slave", tx_owner_slave, 1);
        chk("R2 rx owner master", rx_owner_slave, 0);
        s_tx_push = 1; s_tx_wdata = 8'hA5; tick(); s_tx_push = 0;
        mtx_push(8'h11);
        m_tx_pop = 1; tick(); m_tx_pop = 0;
        chk("R3 owner level", s_tx_level, 1);
        chk("R3 owner data", s_tx_rdata, 8'hA5);
        chk("R3 nonowner level", m_tx_level, 0);
        chk("R3 nonowner empty/full", {m_tx_empty, m_tx_full}, 2'b10);
        chk("R3 nonowner rdata", m_tx_rdata, 0);
        chk("R3 nonowner no flags", irq_raw[5:4], 0);
        mrx_push(8'h3C);
        chk("R2 rx master level", m_rx_level, 1);
        chk("R2 rx slave view", s_rx_level, 0);
        mrx_pop(d);
        chk("R2 rx data", d, 8'h3C);
    endtask

    task automatic t_reassign();
        cfg_tx_slave = 0; tick(3);
        chk("R4 owner held", tx_owner_slave, 1);
        chk("R4 data held", s_tx_level, 1);
        chk("R4 head byte", s_tx_rdata, 8'hA5);
        s_tx_pop = 1; tick(); s_tx_pop = 0;
        tick();
        chk("R4 owner moves when empty", tx_owner_slave, 0);
    endtask

    task automatic t_rx_irq();
        logic [7:0] d;
        rx_trig = 3; clr_all();
        for (int i = 0; i < 3; i++) mrx_push(8'(i));
        tick();
        chk("R5 at trigger", irq_raw[1], 0);
        mrx_push(8'h33); tick();
        chk("R5 above trigger", irq_raw[1], 1);
        chk("R10 masked off", irq, 0);
        irq_mask = 6'b000010;
        #0.1;
        chk("R10 masked vector", irq_masked, 6'b000010);
        chk("R10 irq", irq, 1);
        irq_clr = 6'b000010; tick(); irq_clr = 0; tick();
        chk("R10 w1c", irq_raw[1], 0);
        irq_mask = 0;
        for (int i = 0; i < 4; i++) mrx_push(8'(i));
        tick();
        chk("R7 rx full", irq_raw[2], 1);
        for (int i = 0; i < 8; i++) mrx_pop(d);
    endtask

    task automatic t_tx_irq();
        logic [7:0] d;
        tx_trig = 2; clr_all();
        tick(3);
        chk("R8 stays clear while empty", irq_raw[3], 0);
        for (int i = 0; i < 4; i++) mtx_push(8'(i));
        clr_all();
        chk("R6 cleared", irq_raw[0], 0);
        mtx_pop(d); tick();
        chk("R6 level 3 above trig", irq_raw[0], 0);
        mtx_pop(d); tick();
        chk("R6 level 2 at trig", irq_raw[0], 1);
        chk("R8 not empty yet", irq_raw[3], 0);
        mtx_pop(d); mtx_pop(d); tick();
        chk("R8 drained", irq_raw[3], 1);
        irq_clr = 6'b001000; tick(); irq_clr = 0;
        tick(4);
        chk("R8 no reassert while empty", irq_raw[3], 0);
        mtx_push(8'h5A); mtx_pop(d); tick();
        chk("R8 rearm after refill", irq_raw[3], 1);
    endtask

    initial begin
        fork
            begin
                tick(3); rst_n = 1; tick();
                t_reset();
                t_order_full();
                t_nonowner();
                t_reassign();
                t_rx_irq();
                t_tx_irq();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule